// File: doc/BRIEF.md
# SCSI Controller Command Front-End

This block is the host-facing register file and command decoder of a SCSI bus controller. A byte-wide host bus presents an address, write data and separate write and read strobes. The register index is taken from address bits [5:2], so registers sit on 4-byte strides and address bits [1:0] are ignored. A byte written to the command register is decoded in the same cycle. The block then rewrites its status, interrupt, sequence-step and FIFO-flag registers with fixed codes and may raise a single registered interrupt line.

Toward the back end the block offers two things. The first is a select request that carries the target ID; the back end answers in the same cycle with a present/absent flag. The second is a transfer-start strobe that carries the programmed transfer length. A read of the interrupt register is the host's acknowledge. It drops the interrupt line and clears every status bit except terminal-count, and the interrupt code itself stays readable.

Top module: `scsi_cmd_frontend`

## Requirements
- R1: The register index is addr_i[5:2]. Indices 0, 1, 8, 12, 13, 14 and 15 read back the last byte written to them. A write to index 4 sets a hidden 3-bit target ID and leaves the status register unchanged. Writes to indices 5, 6, 7, 9 and 10 are ignored. Index 2 and indices 9 and 10 read as 0. Index 3 reads back the last command byte.
- R2: A write to index 11 stores only the bits of mask 0x15.
- R3: After rst_ni, or after command opcode 0x02, every register reads 0 except index 14, which reads 0x04. The interrupt line is low and the target ID is 0.
- R4: Opcode 0x01 (flush) sets interrupt (index 5) to 0x08, sequence step (index 6) to 0 and the FIFO count to 0. It leaves the interrupt line unchanged.
- R5: Opcode 0x03 (bus reset) sets interrupt to 0x80. It raises the interrupt line only if bit 6 of index 8 is 0.
- R6: Opcode 0x42 or 0x43 (select) with target ID >= 4, or with sel_present_i low, sets status (index 4) to 0x80, interrupt to 0x20 and sequence step to 0, and it raises the interrupt line.
- R7: A select pulses sel_req_o during the command write, with sel_target_o equal to the target ID. If the target is accepted, the status bit 7 is set, interrupt becomes 0x18 and sequence step becomes 4, and the interrupt line rises. Every select clears the FIFO count.
- R8: Opcode 0x10 pulses xfer_start_o during the write, with xfer_len_o = index1*256 + index0, where 0 means 65536. In DMA mode (command bit 7 = 1) it also sets interrupt to 0x10, sequence step to 0 and the FIFO count to 0. In both modes it raises the interrupt line.
- R9: Opcode 0x11 in DMA mode sets status to 0x93, interrupt to 0x18 and sequence step to 4. Outside DMA mode it sets the FIFO count to 2. In both modes it raises the interrupt line.
- R10: Opcode 0x12 has the effects of 0x11, but it leaves interrupt at 0x20 and sequence step at 0.
- R11: A read of index 5 returns the interrupt code and leaves that code unchanged. From the next cycle the status register keeps only bit 4 (terminal count) and the interrupt line is low. If a set and a clear of the interrupt line meet in the same cycle, the clear wins.
- R12: Opcodes 0x00 and 0x1A, and every opcode not listed, change no status, interrupt, sequence-step or interrupt-line state.
- R13: Each write to index 2 increments the FIFO count, which saturates at 16. Index 7 reads the count in its bits [4:0].
- R14: dma_mode_o equals bit 7 of the last command byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Host byte address; index is bits [5:2] |
| wdata_i | input | 8 | Host write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| irq_o | output | 1 | Registered interrupt request |
| dma_mode_o | output | 1 | DMA mode from the last command |
| sel_req_o | output | 1 | Select request, high during a select command write |
| sel_target_o | output | 3 | Target ID for the select |
| sel_present_i | input | 1 | Back end reports that the target is present |
| xfer_start_o | output | 1 | Transfer start, high during a transfer command write |
| xfer_len_o | output | 17 | Transfer length in bytes, 1 to 65536 |

## Verification
The bench targets five corner cases, each with a distinct failure. A zero transfer length must come out as 65536; a design that passes the raw zero would start an empty transfer. A select must be rejected both for an ID of 4 or more and for a present but absent target; a design that checks only one of the two would report 0x18 for a target that does not exist. The acknowledge read must keep the terminal-count bit and return the interrupt code before any clearing; a design that cleared the whole status or the code would lose the completion evidence. A bus reset under the config mask must stay silent, and the FIFO count must stop at 16 rather than wrap to 0.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;
  localparam int REG_NUM = 16;
  localparam int IDX_W   = $clog2(REG_NUM);
  localparam int IDX_LSB = 2;
  localparam int LEN_W   = 16;

  localparam int IX_LEN_LO = 0;
  localparam int IX_LEN_HI = 1;
  localparam int IX_FIFO   = 2;
  localparam int IX_CMD    = 3;
  localparam int IX_STAT   = 4;
  localparam int IX_INT    = 5;
  localparam int IX_SEQ    = 6;
  localparam int IX_FLAGS  = 7;
  localparam int IX_CFG    = 8;
  localparam int IX_CFG_MK = 11;
  localparam int IX_REV    = 14;

  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_CMPLT    = 7'h11;
  localparam logic [6:0] OP_MSG_ACC  = 7'h12;
  localparam logic [6:0] OP_SET_ATN  = 7'h1A;
  localparam logic [6:0] OP_SEL      = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;

  localparam logic [7:0] INT_FUNC_DONE = 8'h08;
  localparam logic [7:0] INT_BUS_SVC   = 8'h10;
  localparam logic [7:0] INT_DISC      = 8'h20;
  localparam logic [7:0] INT_SCSI_RST  = 8'h80;
  localparam logic [7:0] INT_SEL_OK    = INT_BUS_SVC | INT_FUNC_DONE;

  localparam logic [7:0] ST_PEND  = 8'h80;
  localparam logic [7:0] ST_TC    = 8'h10;
  localparam logic [7:0] ST_CMPLT = ST_PEND | ST_TC | 8'h03;

  localparam logic [7:0] SEQ_IDLE = 8'h00;
  localparam logic [7:0] SEQ_CMDD = 8'h04;

  localparam logic [7:0] CFG_MASK = 8'h15;
  localparam logic [7:0] REV_CODE = 8'h04;

  typedef struct packed {
    logic       int_we;
    logic [7:0] int_val;
    logic       seq_we;
    logic [7:0] seq_val;
    logic       st_we;
    logic [7:0] st_val;
    logic       st_or_pend;
    logic       fifo_clr;
    logic       fifo_two;
    logic       irq_set;
    logic       soft_rst;
    logic       sel_req;
    logic       xfer_go;
  } cmd_act_t;

  function automatic bit reg_is_plain(int i);
    return (i == IX_LEN_LO) || (i == IX_LEN_HI) || (i == IX_CFG) || (i >= IX_CFG_MK);
  endfunction

  function automatic bit reg_is_writable(int i);
    return reg_is_plain(i) || (i == IX_FIFO) || (i == IX_CMD) || (i == IX_STAT);
  endfunction

  function automatic logic [REG_NUM-1:0] writable_mask();
    logic [REG_NUM-1:0] m;
    for (int i = 0; i < REG_NUM; i++) m[i] = reg_is_writable(i);
    return m;
  endfunction

  // opcodes that touch status, interrupt, sequence or irq
  function automatic bit op_has_effect(logic [6:0] op);
    return (op == OP_FLUSH) || (op == OP_CHIP_RST) || (op == OP_BUS_RST) ||
           (op == OP_XFER) || (op == OP_CMPLT) || (op == OP_MSG_ACC) ||
           (op == OP_SEL) || (op == OP_SEL_STOP);
  endfunction
endpackage

// File: rtl/scsi_fe_addr_dec.sv
module scsi_fe_addr_dec
  import scsi_fe_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int ACK_IDX = IX_INT
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [REG_NUM-1:0] wr_hit_o,
  output logic               ack_o
);
  logic unused_addr_lsb;
  assign unused_addr_lsb = ^addr_i[IDX_LSB-1:0];
  assign idx_o = addr_i[IDX_LSB +: IDX_W];

  for (genvar g = 0; g < REG_NUM; g++) begin : g_hit
    assign wr_hit_o[g] = we_i && (idx_o == IDX_W'(g));
  end

  assign ack_o = re_i && (idx_o == IDX_W'(ACK_IDX));
endmodule

// File: rtl/scsi_fe_cmd_dec.sv
module scsi_fe_cmd_dec
  import scsi_fe_pkg::*;
#(
  parameter int NUM_TARGETS = 4,
  parameter int TGT_W       = 3
) (
  input  logic             valid_i,
  input  logic [6:0]       op_i,
  input  logic             dma_i,
  input  logic             bus_rst_quiet_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic             present_i,
  output cmd_act_t         act_o
);
  logic tgt_ok;
  assign tgt_ok = (int'(target_i) < NUM_TARGETS) && present_i;

  always_comb begin
    act_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_FLUSH: begin
          act_o.int_we   = 1'b1;
          act_o.int_val  = INT_FUNC_DONE;
          act_o.seq_we   = 1'b1;
          act_o.seq_val  = SEQ_IDLE;
          act_o.fifo_clr = 1'b1;
        end
        OP_CHIP_RST: act_o.soft_rst = 1'b1;
        OP_BUS_RST: begin
          act_o.int_we  = 1'b1;
          act_o.int_val = INT_SCSI_RST;
          act_o.irq_set = !bus_rst_quiet_i;
        end
        OP_XFER: begin
          act_o.xfer_go = 1'b1;
          act_o.irq_set = 1'b1;
          if (dma_i) begin
            act_o.int_we   = 1'b1;
            act_o.int_val  = INT_BUS_SVC;
            act_o.seq_we   = 1'b1;
            act_o.seq_val  = SEQ_IDLE;
            act_o.fifo_clr = 1'b1;
          end
        end
        OP_CMPLT, OP_MSG_ACC: begin
          act_o.irq_set = 1'b1;
          if (dma_i) begin
            act_o.st_we   = 1'b1;
            act_o.st_val  = ST_CMPLT;
            act_o.int_we  = 1'b1;
            act_o.int_val = INT_SEL_OK;
            act_o.seq_we  = 1'b1;
            act_o.seq_val = SEQ_CMDD;
          end else begin
            act_o.fifo_two = 1'b1;
          end
          if (op_i == OP_MSG_ACC) begin
            act_o.int_we  = 1'b1;
            act_o.int_val = INT_DISC;
            act_o.seq_we  = 1'b1;
            act_o.seq_val = SEQ_IDLE;
          end
        end
        OP_SEL, OP_SEL_STOP: begin
          act_o.sel_req  = 1'b1;
          act_o.fifo_clr = 1'b1;
          act_o.irq_set  = 1'b1;
          act_o.int_we   = 1'b1;
          act_o.seq_we   = 1'b1;
          if (tgt_ok) begin
            act_o.st_or_pend = 1'b1;
            act_o.int_val    = INT_SEL_OK;
            act_o.seq_val    = SEQ_CMDD;
          end else begin
            act_o.st_we   = 1'b1;
            act_o.st_val  = ST_PEND;
            act_o.int_val = INT_DISC;
            act_o.seq_val = SEQ_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_fe_irq.sv
module scsi_fe_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (clr_i) irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
  end

  a_r11_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);
  a_r11_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> irq_o);
endmodule

// File: rtl/scsi_cmd_frontend.sv
module scsi_cmd_frontend
  import scsi_fe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_TARGETS = 4,
  parameter int TGT_W       = 3,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o,
  output logic             dma_mode_o,
  output logic             sel_req_o,
  output logic [TGT_W-1:0] sel_target_o,
  input  logic             sel_present_i,
  output logic             xfer_start_o,
  output logic [LEN_W:0]   xfer_len_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [REG_NUM-1:0] WR_MASK = writable_mask();

  logic [IDX_W-1:0]   idx;
  logic [REG_NUM-1:0] wr_hit;
  logic               ack;
  logic               cmd_wr;
  cmd_act_t           act;

  logic [7:0]       plain_q [REG_NUM];
  logic [7:0]       cmd_q, st_q, int_q, seq_q, st_d;
  logic [TGT_W-1:0] dest_q;
  logic [CNT_W-1:0] cnt_q;

  logic unused_ro_hits;
  assign unused_ro_hits = ^(wr_hit & ~WR_MASK);

  scsi_fe_addr_dec #(.ADDR_W(ADDR_W), .ACK_IDX(IX_INT)) u_addr_dec (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .re_i    (re_i),
    .idx_o   (idx),
    .wr_hit_o(wr_hit),
    .ack_o   (ack)
  );

  assign cmd_wr = wr_hit[IX_CMD];

  scsi_fe_cmd_dec #(.NUM_TARGETS(NUM_TARGETS), .TGT_W(TGT_W)) u_cmd_dec (
    .valid_i        (cmd_wr),
    .op_i           (wdata_i[6:0]),
    .dma_i          (wdata_i[7]),
    .bus_rst_quiet_i(plain_q[IX_CFG][6]),
    .target_i       (dest_q),
    .present_i      (sel_present_i),
    .act_o          (act)
  );

  scsi_fe_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (act.irq_set),
    .clr_i (ack || act.soft_rst),
    .irq_o (irq_o)
  );

  // plain storage registers, with per-index reset value and write mask
  for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
    if (reg_is_plain(g)) begin : g_store
      localparam logic [7:0] RST = (g == IX_REV)    ? REV_CODE : 8'h00;
      localparam logic [7:0] MSK = (g == IX_CFG_MK) ? CFG_MASK : 8'hFF;
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           q <= RST;
        else if (act.soft_rst) q <= RST;
        else if (wr_hit[g])    q <= wdata_i & MSK;
      end
      assign plain_q[g] = q;
    end else begin : g_none
      assign plain_q[g] = 8'h00;
    end
  end

  always_comb begin
    st_d = st_q;
    if (act.st_we)      st_d = act.st_val;
    if (act.st_or_pend) st_d = st_d | ST_PEND;
    if (ack)            st_d = st_d & ST_TC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      st_q   <= '0;
      int_q  <= '0;
      seq_q  <= '0;
      dest_q <= '0;
      cnt_q  <= '0;
    end else if (act.soft_rst) begin
      cmd_q  <= '0;
      st_q   <= '0;
      int_q  <= '0;
      seq_q  <= '0;
      dest_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (cmd_wr)          cmd_q  <= wdata_i;
      if (wr_hit[IX_STAT]) dest_q <= wdata_i[TGT_W-1:0];
      st_q <= st_d;
      if (act.int_we) int_q <= act.int_val;
      if (act.seq_we) seq_q <= act.seq_val;
      if (act.fifo_clr)      cnt_q <= '0;
      else if (act.fifo_two) cnt_q <= CNT_W'(2);
      else if (wr_hit[IX_FIFO] && (cnt_q < CNT_W'(FIFO_DEPTH)))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (int'(idx))
      IX_FIFO:  rdata_o = 8'h00;
      IX_CMD:   rdata_o = cmd_q;
      IX_STAT:  rdata_o = st_q;
      IX_INT:   rdata_o = int_q;
      IX_SEQ:   rdata_o = seq_q;
      IX_FLAGS: rdata_o = 8'(cnt_q);
      default:  rdata_o = plain_q[idx];
    endcase
  end

  assign dma_mode_o   = cmd_q[7];
  assign sel_req_o    = act.sel_req;
  assign sel_target_o = dest_q;
  assign xfer_start_o = act.xfer_go;
  assign xfer_len_o   = ({plain_q[IX_LEN_HI], plain_q[IX_LEN_LO]} == '0) ?
                        (LEN_W+1)'(1) << LEN_W :
                        {1'b0, plain_q[IX_LEN_HI], plain_q[IX_LEN_LO]};

  a_r3_chip_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[6:0] == OP_CHIP_RST) |=>
      (st_q == 8'h00 && int_q == 8'h00 && !irq_o && plain_q[IX_REV] == REV_CODE));
  a_r4_flush_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[6:0] == OP_FLUSH) |=> (int_q == INT_FUNC_DONE && seq_q == SEQ_IDLE));
  a_r5_bus_rst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[6:0] == OP_BUS_RST && plain_q[IX_CFG][6] && !irq_o) |=> !irq_o);
  a_r6_sel_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_req_o && (int'(sel_target_o) >= NUM_TARGETS || !sel_present_i)) |=>
      (st_q == ST_PEND && int_q == INT_DISC && seq_q == SEQ_IDLE && irq_o));
  a_r7_sel_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_req_o |-> (we_i && !re_i));
  a_r8_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (xfer_len_o != '0));
  a_r11_ack_keeps_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !cmd_wr) |=> ((st_q & ~ST_TC) == 8'h00));
  a_r12_inert_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !op_has_effect(wdata_i[6:0])) |=>
      ($stable(st_q) && $stable(int_q) && $stable(seq_q) && $stable(irq_o)));
  a_r13_fifo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FIFO_DEPTH));
endmodule

// File: tb/scsi_cmd_frontend_bench.sv
`timescale 1ns/1ps
module scsi_cmd_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [7:0]  wdata;
  logic        we, re;
  logic [7:0]  rdata;
  logic        irq, dma_mode, sel_req, sel_present, xfer_start;
  logic [2:0]  sel_target;
  logic [16:0] xfer_len;
  logic [7:0]  present_mask;

  always #2.5 clk = ~clk;

  assign sel_present = present_mask[sel_target];

  scsi_cmd_frontend u_scsi_cmd_frontend (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .irq_o(irq), .dma_mode_o(dma_mode), .sel_req_o(sel_req),
    .sel_target_o(sel_target), .sel_present_i(sel_present),
    .xfer_start_o(xfer_start), .xfer_len_o(xfer_len)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [7:0] m_reg [16];
  logic [7:0] m_cmd, m_st, m_int, m_seq;
  int         m_cnt;
  logic       m_irq;
  logic [2:0] m_dest;
  logic       cap_sel, cap_xfer;
  logic [2:0] cap_tgt;
  logic [16:0] cap_len;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_reg[14] = 8'h04;
    m_cmd = 0; m_st = 0; m_int = 0; m_seq = 0; m_cnt = 0; m_irq = 0; m_dest = 0;
  endtask

  function automatic logic [16:0] exp_len();
    logic [15:0] v = {m_reg[1], m_reg[0]};
    return (v == 16'h0) ? 17'h10000 : {1'b0, v};
  endfunction

  function automatic logic [7:0] m_read(input int idx);
    case (idx)
      2: return 8'h00;
      3: return m_cmd;
      4: return m_st;
      5: return m_int;
      6: return m_seq;
      7: return 8'(m_cnt);
      default: return m_reg[idx];
    endcase
  endfunction

  task automatic model_cmd(input logic [7:0] d);
    logic dma = d[7];
    m_cmd = d;
    case (d[6:0])
      7'h01: begin m_int = 8'h08; m_seq = 0; m_cnt = 0; end
      7'h02: model_reset();
      7'h03: begin m_int = 8'h80; if (!m_reg[8][6]) m_irq = 1; end
      7'h10: begin
        if (dma) begin m_int = 8'h10; m_seq = 0; m_cnt = 0; end
        m_irq = 1;
      end
      7'h11, 7'h12: begin
        if (dma) begin m_st = 8'h93; m_int = 8'h18; m_seq = 8'h04; end
        else m_cnt = 2;
        if (d[6:0] == 7'h12) begin m_int = 8'h20; m_seq = 0; end
        m_irq = 1;
      end
      7'h42, 7'h43: begin
        m_cnt = 0;
        if (m_dest >= 3'd4 || !present_mask[m_dest]) begin
          m_st = 8'h80; m_int = 8'h20; m_seq = 0;
        end else begin
          m_st = m_st | 8'h80; m_int = 8'h18; m_seq = 8'h04;
        end
        m_irq = 1;
      end
      default: ;
    endcase
  endtask

  task automatic model_write(input int idx, input logic [7:0] d);
    case (idx)
      0, 1, 8, 12, 13, 14, 15: m_reg[idx] = d;
      11: m_reg[idx] = d & 8'h15;
      2:  if (m_cnt < 16) m_cnt++;
      3:  model_cmd(d);
      4:  m_dest = d[2:0];
      default: ;
    endcase
  endtask

  task automatic do_write(input int idx, input logic [7:0] d, input logic [1:0] lsb = 2'b00);
    @(negedge clk);
    addr = {idx[3:0], lsb}; wdata = d; we = 1'b1;
    #1;
    cap_sel = sel_req; cap_tgt = sel_target; cap_xfer = xfer_start; cap_len = xfer_len;
    @(negedge clk);
    we = 1'b0;
    model_write(idx, d);
  endtask

  task automatic do_read(input int idx, output logic [7:0] v);
    @(negedge clk);
    addr = {idx[3:0], 2'b00}; re = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    re = 1'b0;
    if (idx == 5) begin m_st = m_st & 8'h10; m_irq = 0; end
  endtask

  task automatic rd_chk(input string req, input int idx);
    logic [7:0] exp, v;
    exp = m_read(idx);
    do_read(idx, v);
    chk(req, $sformatf("reg%0d", idx), v, exp);
  endtask

  task automatic irq_chk(input string req);
    #1 chk(req, "irq_o", irq, m_irq);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] ops [12];
    void'($urandom(32'h5C51_0001));
    rst_n = 1'b0; we = 0; re = 0; addr = 0; wdata = 0; present_mask = 8'h00;
    cap_sel = 0; cap_xfer = 0; cap_tgt = 0; cap_len = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    for (int i = 0; i < 16; i++) if (i != 5) rd_chk("R3", i);
    irq_chk("R3");

    // R1 addressing and ignored writes
    do_write(12, 8'h5A, 2'b11); rd_chk("R1", 12);
    do_write(0, 8'h34, 2'b01);  rd_chk("R1", 0);
    do_write(6, 8'hEE); rd_chk("R1", 6);
    do_write(9, 8'hEE); rd_chk("R1", 9);
    do_write(4, 8'hFF); rd_chk("R1", 4);

    // R2 masked config
    do_write(11, 8'hFF); rd_chk("R2", 11);

    // R13 fifo saturation
    for (int i = 0; i < 18; i++) do_write(2, 8'(i));
    rd_chk("R13", 7);
    chk("R13", "count", m_cnt, 16);

    // R4 flush
    do_write(3, 8'h01); rd_chk("R4", 5); rd_chk("R4", 6); rd_chk("R4", 7); irq_chk("R4");

    // R5 bus reset masked / unmasked, R11 ack
    do_write(8, 8'h40); do_write(3, 8'h03); irq_chk("R5"); chk("R5", "irq_masked", irq, 0);
    do_write(8, 8'h00); do_write(3, 8'h03); irq_chk("R5");
    rd_chk("R11", 5); irq_chk("R11"); rd_chk("R11", 5);

    // R6 rejects
    do_write(4, 8'h05); do_write(3, 8'h42);
    chk("R7", "sel_req", cap_sel, 1);
    rd_chk("R6", 4); rd_chk("R6", 5); rd_chk("R6", 6); irq_chk("R6");
    rd_chk("R11", 5); rd_chk("R11", 4);
    present_mask = 8'b0000_0100;
    do_write(4, 8'h01); do_write(3, 8'h43); rd_chk("R6", 5); rd_chk("R11", 5);

    // R7 accepted
    do_write(4, 8'h02); do_write(3, 8'h42);
    chk("R7", "sel_target", cap_tgt, 3'd2);
    rd_chk("R7", 4); rd_chk("R7", 5); rd_chk("R7", 6); irq_chk("R7");
    rd_chk("R11", 5);

    // R8 transfer length
    do_write(0, 8'h00); do_write(1, 8'h00); do_write(3, 8'h90);
    chk("R8", "xfer_start", cap_xfer, 1); chk("R8", "len_zero", cap_len, 17'h10000);
    rd_chk("R8", 5); irq_chk("R8"); chk("R14", "dma_mode", dma_mode, 1);
    rd_chk("R11", 5);
    do_write(0, 8'h23); do_write(1, 8'h01); do_write(3, 8'h10);
    chk("R8", "len", cap_len, 17'h00123); rd_chk("R8", 5); irq_chk("R8");
    chk("R14", "dma_mode", dma_mode, 0);
    rd_chk("R11", 5);

    // R9 / R10 completion
    do_write(3, 8'h91); rd_chk("R9", 4); rd_chk("R9", 5); rd_chk("R9", 6);
    rd_chk("R11", 5); rd_chk("R11", 4);
    do_write(3, 8'h11); rd_chk("R9", 7); irq_chk("R9"); rd_chk("R11", 5);
    do_write(3, 8'h92); rd_chk("R10", 4); rd_chk("R10", 5); rd_chk("R10", 6); irq_chk("R10");
    rd_chk("R11", 5);

    // R12 inert opcodes
    do_write(3, 8'h1A); do_write(3, 8'h00); do_write(3, 8'h55);
    rd_chk("R12", 4); rd_chk("R12", 5); rd_chk("R12", 6); irq_chk("R12");
    rd_chk("R1", 3);

    // R3 chip reset command
    do_write(3, 8'h03); do_write(14, 8'hAA);
    do_write(3, 8'h82);
    for (int i = 0; i < 16; i++) if (i != 5) rd_chk("R3", i);
    irq_chk("R3"); chk("R3", "dma_mode", dma_mode, 0);

    // random phase
    ops = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12, 7'h1A, 7'h42, 7'h43, 7'h42, 7'h10};
    for (int n = 0; n < 500; n++) begin
      int r = $urandom_range(0, 9);
      if (r <= 2) begin
        int idx = $urandom_range(0, 15);
        if (idx == 3) idx = 2;
        do_write(idx, 8'($urandom));
        irq_chk("R1");
      end else if (r <= 5) begin
        logic [6:0] op = ($urandom_range(0, 12) == 12) ? 7'($urandom) : ops[$urandom_range(0, 11)];
        logic [7:0] d = {1'($urandom_range(0, 1)), op};
        logic [16:0] el = exp_len();
        do_write(3, d);
        if (op == 7'h10) chk("R8", "rand_len", cap_len, el);
        chk("R7", "rand_sel", cap_sel, (op == 7'h42 || op == 7'h43));
        irq_chk("R12");
        rd_chk("R9", 4); rd_chk("R10", 6); rd_chk("R13", 7);
        chk("R14", "dma_mode", dma_mode, m_cmd[7]);
      end else if (r <= 7) begin
        rd_chk("R11", 5); irq_chk("R11");
      end else if (r == 8) begin
        int idx = $urandom_range(0, 15);
        if (idx == 5) idx = 11;
        rd_chk("R1", idx);
      end else begin
        present_mask = 8'($urandom);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule